// File: doc/BRIEF.md
# Front-to-Back Ray Compositing Unit

This unit sits at the end of a slice-parallel ray-casting pipeline. Each cycle it may take one shaded colour sample (red, green, blue and opacity) with a small control tag. It merges the sample into the running result of the ray it belongs to, and it keeps those running results in an on-chip buffer. That buffer holds one slice worth of partial rays. The unit tracks its own position in the volume (column, row, slice) with internal counters, so the sample stream carries no addresses.

For each sample the unit fetches the partial result that the ray left in the previous slice. Two step bits in the tag say whether the ray moved one column and/or one row since then, and so choose which entry to fetch. The unit then composites front to back. It either writes the new partial result back at the current position, or emits it as a finished pixel together with its column and row when the tag says the ray leaves the volume. Samples marked invalid advance the position but change nothing. A start mark restarts the traversal at the origin.

Top module: `ray_accum_ftb`

## Requirements
- R1: With M = 2^CW-1, stored opacity A and sample opacity a, the weight is w = round((M-A)*a/M) and the new opacity is min(M, A+w). Rounding is to nearest; exact halves cannot occur.
- R2: Each colour channel becomes min(M, C + round(w*c/M)), where C is the stored channel and c is the sample channel.
- R3: A sample accepted with tag_exit_x or tag_exit_y high, and tag_forget low, produces a single pix_valid pulse two rising edges after acceptance. The pulse carries the composited RGBA. pix_valid is never high at any other time.
- R4: A sample without exit and without forget stores its composited value at its own position (x,y). The ray's next sample, one slice later at position (x',y'), reads the entry at (x'+tag_step_x, y'+tag_step_y).
- R5: The partial result is taken as zero (transparent black) when the sample lies in slice 0, or when the read column is at least NX, or the read row is at least NY.
- R6: A sample that finishes a ray writes zero into its own entry, so a later read of that entry starts from transparent.
- R7: A sample with tag_forget high emits no pixel and leaves the buffer unchanged, but still advances the position.
- R8: A sample with tag_start high is processed at column 0, row 0, slice 0, whatever the counters held.
- R9: The position advances once per accepted sample: the column counts first, then the row, then the slice. The slice wraps modulo NZ. pix_x and pix_y give the column and row of the finishing sample.
- R10: When a sample reads the entry written by the sample accepted in the cycle just before it, it sees that new value.
- R11: After reset pix_valid is low, every buffer entry is zero and the position is column 0, row 0, slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_r | input | CW | Sample red |
| smp_g | input | CW | Sample green |
| smp_b | input | CW | Sample blue |
| smp_a | input | CW | Sample opacity |
| tag_start | input | 1 | Restart traversal at the origin with this sample |
| tag_forget | input | 1 | Sample is invalid; no effect besides advancing the position |
| tag_exit_x | input | 1 | Ray leaves through a column boundary after this sample |
| tag_exit_y | input | 1 | Ray leaves through a row boundary after this sample |
| tag_step_x | input | 1 | Ray moved one column since the previous slice |
| tag_step_y | input | 1 | Ray moved one row since the previous slice |
| pix_valid | output | 1 | Finished pixel strobe |
| pix_r | output | CW | Pixel red |
| pix_g | output | CW | Pixel green |
| pix_b | output | CW | Pixel blue |
| pix_a | output | CW | Pixel opacity |
| pix_x | output | clog2(NX) | Base-plane column of the pixel |
| pix_y | output | clog2(NY) | Base-plane row of the pixel |

## Verification
A finished pixel is due two rising edges after its sample is accepted. The first edge registers the buffer read and the tag. The second registers the composite into the output. The bench model handles each sample as it is driven and files the expected strobe, colour and position under the edge count plus two. At every falling edge it compares the outputs against the entry for the current edge count, so missing, extra and late pulses all show up. Buffer writes take effect one edge after acceptance, so the sample right behind sees them only through the forwarding path. The model lets every sample see all earlier updates, which exercises that path.

// File: rtl/ray_accum_pkg.sv
package ray_accum_pkg;

   typedef struct packed {
      logic start;
      logic forget;
      logic exit_x;
      logic exit_y;
      logic step_x;
      logic step_y;
   } tag_t;

endpackage

// File: rtl/ray_accum_walk.sv
module ray_accum_walk #(
   parameter int NX = 8,
   parameter int NY = 8,
   parameter int NZ = 8,
   parameter int XW = 3,
   parameter int YW = 3,
   parameter int ZW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          restart,
   output logic [XW-1:0] cur_x,
   output logic [YW-1:0] cur_y,
   output logic [ZW-1:0] cur_z
);

   logic [XW-1:0] cnt_x;
   logic [YW-1:0] cnt_y;
   logic [ZW-1:0] cnt_z;

   assign cur_x = restart ? '0 : cnt_x;
   assign cur_y = restart ? '0 : cnt_y;
   assign cur_z = restart ? '0 : cnt_z;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_x <= '0;
         cnt_y <= '0;
         cnt_z <= '0;
      end else if (adv) begin
         if (int'(cur_x) == NX - 1) begin
            cnt_x <= '0;
            if (int'(cur_y) == NY - 1) begin
               cnt_y <= '0;
               cnt_z <= (int'(cur_z) == NZ - 1) ? '0 : cur_z + 1'b1;
            end else begin
               cnt_y <= cur_y + 1'b1;
               cnt_z <= cur_z;
            end
         end else begin
            cnt_x <= cur_x + 1'b1;
            cnt_y <= cur_y;
            cnt_z <= cur_z;
         end
      end
   end

   assert_pos_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_x) < NX) && (int'(cnt_y) < NY) && (int'(cnt_z) < NZ));

endmodule

// File: rtl/ray_accum_store.sv
module ray_accum_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("ray_accum_store: DEPTH exceeds address range");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en) mem[wr_addr] <= wr_data;
         if (rd_en) rd_data <= (wr_en && (wr_addr == rd_addr)) ? wr_data : mem[rd_addr];
      end
   end

   assert_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && (rd_addr == wr_addr)) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/ray_accum_blend.sv
module ray_accum_blend #(
   parameter int CW = 8
) (
   input  logic [4*CW-1:0] prior,
   input  logic [4*CW-1:0] smp,
   output logic [4*CW-1:0] result,
   output logic [CW-1:0]   weight
);

   localparam int MAXV = (1 << CW) - 1;
   localparam int HALF = 1 << (CW - 1);

   function automatic logic [CW-1:0] div_max(input logic [2*CW-1:0] v);
      logic [2*CW:0] s;
      logic [2*CW:0] u;
      s = {1'b0, v} + (2*CW+1)'(HALF);
      u = s + (s >> CW);
      return u[2*CW-1:CW];
   endfunction

   function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] x, input logic [CW-1:0] y);
      logic [CW:0] s;
      s = {1'b0, x} + {1'b0, y};
      return s[CW] ? CW'(MAXV) : s[CW-1:0];
   endfunction

   logic [CW-1:0] acc_a;
   logic [CW-1:0] new_a;
   logic [CW-1:0] w;

   assign acc_a = prior[CW-1:0];
   assign new_a = smp[CW-1:0];
   assign w     = div_max({{CW{1'b0}}, ~acc_a} * {{CW{1'b0}}, new_a});
   assign weight = w;
   assign result[CW-1:0] = sat_add(acc_a, w);

   for (genvar ch = 1; ch < 4; ch++) begin : g_chan
      logic [CW-1:0] inc;
      assign inc = div_max({{CW{1'b0}}, w} * {{CW{1'b0}}, smp[ch*CW +: CW]});
      assign result[ch*CW +: CW] = sat_add(prior[ch*CW +: CW], inc);
   end

endmodule

// File: rtl/ray_accum_ftb.sv
module ray_accum_ftb
   import ray_accum_pkg::*;
#(
   parameter int CW = 8,
   parameter int NX = 8,
   parameter int NY = 8,
   parameter int NZ = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_valid,
   input  logic [CW-1:0]         smp_r,
   input  logic [CW-1:0]         smp_g,
   input  logic [CW-1:0]         smp_b,
   input  logic [CW-1:0]         smp_a,
   input  logic                  tag_start,
   input  logic                  tag_forget,
   input  logic                  tag_exit_x,
   input  logic                  tag_exit_y,
   input  logic                  tag_step_x,
   input  logic                  tag_step_y,
   output logic                  pix_valid,
   output logic [CW-1:0]         pix_r,
   output logic [CW-1:0]         pix_g,
   output logic [CW-1:0]         pix_b,
   output logic [CW-1:0]         pix_a,
   output logic [$clog2(NX)-1:0] pix_x,
   output logic [$clog2(NY)-1:0] pix_y
);

   localparam int XW    = $clog2(NX);
   localparam int YW    = $clog2(NY);
   localparam int ZW    = (NZ > 1) ? $clog2(NZ) : 1;
   localparam int DEPTH = NX * NY;
   localparam int AW    = $clog2(DEPTH);
   localparam int DW    = 4 * CW;

   if (CW < 4 || CW > 12) begin : g_bad_cw
      $error("ray_accum_ftb: CW must lie in 4..12");
   end
   if (NX < 2 || NY < 2 || NZ < 2) begin : g_bad_dim
      $error("ray_accum_ftb: NX, NY and NZ must each be at least 2");
   end

   tag_t tg;
   assign tg = '{start: tag_start, forget: tag_forget, exit_x: tag_exit_x,
                 exit_y: tag_exit_y, step_x: tag_step_x, step_y: tag_step_y};

   // position of the incoming sample
   logic [XW-1:0] cur_x;
   logic [YW-1:0] cur_y;
   logic [ZW-1:0] cur_z;

   ray_accum_walk #(.NX(NX), .NY(NY), .NZ(NZ), .XW(XW), .YW(YW), .ZW(ZW)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (smp_valid),
      .restart (tg.start),
      .cur_x   (cur_x),
      .cur_y   (cur_y),
      .cur_z   (cur_z)
   );

   // entry the ray left behind in the previous slice
   logic [XW:0]   rd_x;
   logic [YW:0]   rd_y;
   logic          rd_zero;
   logic [AW-1:0] rd_addr;

   assign rd_x    = {1'b0, cur_x} + {{XW{1'b0}}, tg.step_x};
   assign rd_y    = {1'b0, cur_y} + {{YW{1'b0}}, tg.step_y};
   assign rd_zero = (cur_z == '0) || (int'(rd_x) >= NX) || (int'(rd_y) >= NY);
   assign rd_addr = AW'(int'(rd_y[YW-1:0]) * NX + int'(rd_x[XW-1:0]));

   // stage 1: buffer data returns, composite is formed
   logic          s1_v;
   logic          s1_forget;
   logic          s1_exit;
   logic          s1_zero;
   logic [XW-1:0] s1_x;
   logic [YW-1:0] s1_y;
   logic [DW-1:0] s1_smp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_forget <= 1'b0;
         s1_exit   <= 1'b0;
         s1_zero   <= 1'b0;
         s1_x      <= '0;
         s1_y      <= '0;
         s1_smp    <= '0;
      end else begin
         s1_v      <= smp_valid;
         s1_forget <= tg.forget;
         s1_exit   <= tg.exit_x | tg.exit_y;
         s1_zero   <= rd_zero;
         s1_x      <= cur_x;
         s1_y      <= cur_y;
         s1_smp    <= {smp_r, smp_g, smp_b, smp_a};
      end
   end

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] prior;
   logic [DW-1:0] blended;
   logic [CW-1:0] weight;

   assign wr_en   = s1_v && !s1_forget;
   assign wr_addr = AW'(int'(s1_y) * NX + int'(s1_x));
   assign wr_data = s1_exit ? '0 : blended;
   assign prior   = s1_zero ? '0 : rd_data;

   ray_accum_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (smp_valid),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   ray_accum_blend #(.CW(CW)) u_blend (
      .prior  (prior),
      .smp    (s1_smp),
      .result (blended),
      .weight (weight)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_valid <= 1'b0;
         pix_r     <= '0;
         pix_g     <= '0;
         pix_b     <= '0;
         pix_a     <= '0;
         pix_x     <= '0;
         pix_y     <= '0;
      end else begin
         pix_valid <= s1_v && !s1_forget && s1_exit;
         if (s1_v && !s1_forget && s1_exit) begin
            {pix_r, pix_g, pix_b, pix_a} <= blended;
            pix_x <= s1_x;
            pix_y <= s1_y;
         end
      end
   end

   assert_pix_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> $past(smp_valid && (tag_exit_x || tag_exit_y) && !tag_forget, 2));

   assert_forget_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && tag_forget) |=> ##1 !pix_valid);

   assert_alpha_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v |-> (blended[CW-1:0] >= prior[CW-1:0]));

   assert_colour_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v |-> ((blended[DW-1 -: CW] >= prior[DW-1 -: CW]) &&
                ((blended[DW-1 -: CW] - prior[DW-1 -: CW]) <= weight)));

endmodule

// File: tb/sim_ray_accum_ftb.sv
`timescale 1ns/1ps
module sim_ray_accum_ftb;

   localparam int CW = 8;
   localparam int NX = 2;
   localparam int NY = 2;
   localparam int NZ = 3;
   localparam int M  = 255;
   localparam int NSLOT = 8192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [7:0] smp_r = '0, smp_g = '0, smp_b = '0, smp_a = '0;
   logic tag_start = 1'b0, tag_forget = 1'b0, tag_exit_x = 1'b0, tag_exit_y = 1'b0;
   logic tag_step_x = 1'b0, tag_step_y = 1'b0;
   logic pix_valid;
   logic [7:0] pix_r, pix_g, pix_b, pix_a;
   logic [0:0] pix_x, pix_y;

   always #2.5 clk = ~clk;

   ray_accum_ftb #(.CW(CW), .NX(NX), .NY(NY), .NZ(NZ)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_r(smp_r), .smp_g(smp_g), .smp_b(smp_b), .smp_a(smp_a),
      .tag_start(tag_start), .tag_forget(tag_forget), .tag_exit_x(tag_exit_x),
      .tag_exit_y(tag_exit_y), .tag_step_x(tag_step_x), .tag_step_y(tag_step_y),
      .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .pix_a(pix_a), .pix_x(pix_x), .pix_y(pix_y)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   bit    exp_v [NSLOT];
   int    exp_c [NSLOT];
   int    exp_x [NSLOT];
   int    exp_y [NSLOT];
   string exp_l [NSLOT];

   // reference model state
   int mbuf [NX*NY];
   bit mclr [NX*NY];
   int mx = 0, my = 0, mz = 0;
   int last_wr_addr = -1;
   int last_send = -10;
   int seed = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int rdiv(input int v);
      return (v + 127) / 255;
   endfunction

   function automatic int sat(input int v);
      return (v > M) ? M : v;
   endfunction

   function automatic int nextrnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      return seed & 32'h7fff_ffff;
   endfunction

   always @(negedge clk) begin
      if (chk_on) begin
         checks++;
         if (pix_valid !== exp_v[cyc % NSLOT]) begin
            errors++;
            $display("FAIL %s strobe at edge %0d: actual %0b expected %0b",
                     exp_v[cyc % NSLOT] ? exp_l[cyc % NSLOT] : "R3", cyc, pix_valid, exp_v[cyc % NSLOT]);
         end else if (exp_v[cyc % NSLOT]) begin
            checks++;
            if ({pix_r, pix_g, pix_b, pix_a} !== 32'(exp_c[cyc % NSLOT])) begin
               errors++;
               $display("FAIL %s R1 R2 colour at edge %0d: actual %h expected %h",
                        exp_l[cyc % NSLOT], cyc, {pix_r, pix_g, pix_b, pix_a}, 32'(exp_c[cyc % NSLOT]));
            end
            checks++;
            if (int'(pix_x) != exp_x[cyc % NSLOT] || int'(pix_y) != exp_y[cyc % NSLOT]) begin
               errors++;
               $display("FAIL R9 position at edge %0d: actual %0d,%0d expected %0d,%0d",
                        cyc, pix_x, pix_y, exp_x[cyc % NSLOT], exp_y[cyc % NSLOT]);
            end
         end
         exp_v[cyc % NSLOT] = 1'b0;
      end
   end

   task automatic idle();
      @(negedge clk);
      smp_valid = 1'b0;
      tag_start = 1'b0; tag_forget = 1'b0; tag_exit_x = 1'b0; tag_exit_y = 1'b0;
      tag_step_x = 1'b0; tag_step_y = 1'b0;
   endtask

   task automatic send(input bit st, input bit fg, input bit ex, input bit ey,
                       input bit sx, input bit sy, input int r, input int g,
                       input int b, input int a);
      int px, py, pz, rx, ry, ra, pr, pg, pb, pa, w, nr, ng, nb, na, slot, wa;
      bit zero, hazard;
      string lbl;
      @(negedge clk);
      smp_valid = 1'b1;
      tag_start = st; tag_forget = fg; tag_exit_x = ex; tag_exit_y = ey;
      tag_step_x = sx; tag_step_y = sy;
      smp_r = 8'(r); smp_g = 8'(g); smp_b = 8'(b); smp_a = 8'(a);
      // model: position (R8), read selection (R4, R5)
      px = st ? 0 : mx; py = st ? 0 : my; pz = st ? 0 : mz;
      rx = px + int'(sx); ry = py + int'(sy);
      zero = (pz == 0) || (rx >= NX) || (ry >= NY);
      ra = zero ? -1 : ry * NX + rx;
      hazard = !zero && (last_send == cyc - 1) && (last_wr_addr == ra);
      pr = 0; pg = 0; pb = 0; pa = 0;
      if (!zero) begin
         pr = (mbuf[ra] >> 24) & 255; pg = (mbuf[ra] >> 16) & 255;
         pb = (mbuf[ra] >> 8) & 255;  pa = mbuf[ra] & 255;
      end
      if (fg)               lbl = "R7";
      else if (st)          lbl = "R8";
      else if (hazard)      lbl = "R10";
      else if (zero)        lbl = "R5";
      else if (mclr[ra])    lbl = "R6";
      else                  lbl = "R4";
      wa = py * NX + px;
      if (!fg) begin
         w  = rdiv((M - pa) * a);
         na = sat(pa + w);
         nr = sat(pr + rdiv(w * r));
         ng = sat(pg + rdiv(w * g));
         nb = sat(pb + rdiv(w * b));
         if (ex || ey) begin
            slot = (cyc + 2) % NSLOT;
            exp_v[slot] = 1'b1;
            exp_c[slot] = (nr << 24) | (ng << 16) | (nb << 8) | na;
            exp_x[slot] = px;
            exp_y[slot] = py;
            exp_l[slot] = lbl;
            mbuf[wa] = 0;          // R6
            mclr[wa] = 1'b1;
         end else begin
            mbuf[wa] = (nr << 24) | (ng << 16) | (nb << 8) | na;
            mclr[wa] = 1'b0;
         end
         last_wr_addr = wa;
      end else begin
         last_wr_addr = -1;
      end
      last_send = cyc;
      // R9 traversal order
      if (px == NX - 1) begin
         mx = 0;
         if (py == NY - 1) begin my = 0; mz = (pz == NZ - 1) ? 0 : pz + 1; end
         else begin my = py + 1; mz = pz; end
      end else begin
         mx = px + 1; my = py; mz = pz;
      end
   endtask

   task automatic random_run(input int len, input bit gaps);
      for (int i = 0; i < len; i++) begin
         bit st, fg, ex;
         int a;
         st = (i == 0);
         fg = (nextrnd() % 7) == 0;
         ex = (!st && mz == NZ - 1) || ((nextrnd() % 5) == 0);
         a  = nextrnd() % 4 == 0 ? ((nextrnd() % 2) ? 255 : 0) : nextrnd() % 256;
         send(st, fg, ex, (nextrnd() % 9) == 0, 1'(nextrnd()), 1'(nextrnd()),
              nextrnd() % 256, nextrnd() % 256, nextrnd() % 256, a);
         if (gaps && (nextrnd() % 3) == 0) idle();
      end
   endtask

   initial begin
      for (int i = 0; i < NSLOT; i++) exp_v[i] = 1'b0;
      for (int i = 0; i < NX*NY; i++) begin mbuf[i] = 0; mclr[i] = 1'b0; end
      repeat (4) @(negedge clk);
      // R11: strobe low while and right after reset
      checks++;
      if (pix_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset strobe: actual %0b expected 0", pix_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk_on = 1'b1;

      // R11: all of slice 0 forgotten, slice 1 reads entries cleared by reset
      for (int i = 0; i < NX*NY; i++) send(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9, 9, 9, 9);
      send(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 200, 100, 50, 128);
      idle(); idle();

      // R1 R2 sweep over colour and opacity from a transparent start
      for (int c = 0; c < 256; c += 15)
         for (int a = 0; a < 256; a += 15)
            send(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, c, 255 - c, (c + a) % 256, a);
      idle(); idle();

      // R10: fill slice 0, then the first sample of slice 1 reads the last one written
      send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10, 20, 30, 40);
      send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11, 21, 31, 41);
      send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12, 22, 32, 42);
      send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 250, 200, 150, 100);
      send(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 90, 80, 70, 160);
      idle(); idle();

      // R4 R5 R6 R7 R8 R9: streamed volumes, back to back and with gaps
      for (int v = 0; v < 40; v++) random_run(4 + (nextrnd() % 20), v[0]);
      for (int v = 0; v < 10; v++) random_run(NX*NY*NZ, 1'b0);
      repeat (4) idle();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R3 watchdog expired: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule